// File: doc/BRIEF.md
# Word-Bus I/O Access Sequencer

The sequencer takes one I/O fragment request (a byte address, a length of one to three bytes, and a direction) and turns it into the exact series of 16-bit peripheral-bus cycles it needs. The bus offers word reads, word writes and byte writes. It has no byte read. A bus read may have side effects at the target, so the block never issues a cycle beyond the minimal set for the case. A partial write is never done as read-modify-write: bytes that must not change are reached with byte-write cycles.

A request is taken in the cycle `req_valid` is high while `busy` is low. The block then raises `bus_cyc` for each bus cycle and holds address, data and cycle type until `bus_ack`. After the last acknowledge it pulses `done`, and for reads the assembled 32-bit value is then on `rdata`. A length of zero is refused with a one-cycle `err` pulse, and no bus cycle is issued for it.

The controller has five states. `ST_IDLE` waits for a request. It moves to `ST_FIRST` on a valid length and to `ST_REJECT` on a zero length. `ST_FIRST` drives the first bus cycle. On acknowledge it goes to `ST_SECOND` when the plan has two cycles, and to `ST_FINISH` otherwise. `ST_SECOND` drives the second cycle and moves to `ST_FINISH` on acknowledge. `ST_FINISH` pulses `done`, `ST_REJECT` pulses `err`, and both return to `ST_IDLE` unconditionally.

Top module: `wbus_io_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `bus_cyc` are all low. `bus_cyc` is never high while `busy` is low.
- R2: Every read cycle is a word cycle (`bus_byte`=0, `bus_we`=0). Every word cycle, read or write, carries an even `bus_addr`.
- R3: A read whose length plus address bit 0 is at most 2 issues exactly one word read at the address with bit 0 cleared. The word goes to `rdata[31:16]` (low half zero) when address bit 1 is 1, and to `rdata[15:0]` (high half zero) otherwise.
- R4: Any other read issues two word reads, at the address with bit 0 cleared and then 2 above it. `rdata` is {second word, first word}.
- R5: A 1-byte write is one byte-write cycle at the request address, at any offset. The byte travels on `bus_wdata[7:0]` with `bus_wdata[15:8]`=0, and this lane rule holds for every byte write.
- R6: A 2-byte write at an even address is one word write of `req_wdata[15:0]`. At an odd address it is a byte write of bits 7:0 at the address, then a byte write of bits 15:8 at the address plus 1.
- R7: A 3-byte write at an odd address is a byte write of bits 7:0 at the address, then a word write of bits 23:8 at the address plus 1. At an even address it is a word write of bits 15:0 at the address, then a byte write of bits 23:16 at the address plus 2.
- R8: While `bus_cyc` is high and `bus_ack` is low, the next cycle keeps `bus_cyc` high and leaves address, direction, type and write data unchanged.
- R9: `done` pulses for exactly one cycle, in the cycle after the acknowledge of the last bus cycle. `busy` is low in the cycle that follows.
- R10: A request with `req_len`=0 yields a one-cycle `err` pulse one cycle after it is taken. It issues no bus cycle and raises no `done`.
- R11: A request presented while `busy` is high is ignored: the bus cycles of the running request are unchanged.
- R12: No request produces more than the listed cycles, and never more than two acknowledged cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the fragment |
| req_len | input | 2 | Length in bytes, 1 to 3 |
| req_wdata | input | 24 | Write data, right-aligned |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a refused length |
| rdata | output | 32 | Assembled read result, valid from `done` onward |
| bus_cyc | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write cycle |
| bus_byte | output | 1 | 1 = byte write, 0 = word cycle |
| bus_addr | output | ADDR_W | Bus cycle byte address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read word |
| bus_ack | input | 1 | Cycle acknowledge |

## Verification
Every length runs at all four byte offsets in both directions, so each of the write splits and both read widths are reached at least once. These directed cases separate even from odd placement and show whether the half-word choice in the one-word read follows address bit 1. Randomised requests with random acknowledge latency mix the cases and hold cycles open for several clocks, which exposes any field that moves before its acknowledge. A stray request injected mid-transfer and a zero length show whether the sequencer starts anything it should not.

// File: rtl/wbseq_pkg.sv
package wbseq_pkg;

    localparam int BUS_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int RES_W   = 2 * BUS_W;
    localparam int WDATA_W = 3 * BYTE_W;
    localparam int NSLOT   = 2;
    localparam int OFF_W   = 2;

    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_WRD  = 2'd1,
        CK_WWR  = 2'd2,
        CK_BWR  = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e         kind;
        logic [OFF_W-1:0]  off;
        logic [BUS_W-1:0]  data;
    } slot_t;

    typedef struct packed {
        slot_t [NSLOT-1:0] slot;
        logic              two;
        logic              hi;
        logic              align;
    } plan_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FIRST  = 3'd1,
        ST_SECOND = 3'd2,
        ST_FINISH = 3'd3,
        ST_REJECT = 3'd4
    } st_e;

endpackage

// File: rtl/wbseq_planner.sv
module wbseq_planner
    import wbseq_pkg::*;
(
    input  logic               wr,
    input  logic [1:0]         a_lo,
    input  logic [1:0]         len,
    input  logic [WDATA_W-1:0] wdata,
    output plan_t              plan,
    output logic               bad
);

    localparam logic [BYTE_W-1:0] ZB = '0;

    logic [2:0] span;

    always_comb begin
        span = 3'(len) + 3'(a_lo[0]);
    end

    always_comb begin
        plan = '0;
        bad  = (len == 2'd0);
        if (!wr) begin
            plan.align        = 1'b1;
            plan.two          = (span > 3'd2);
            plan.hi           = a_lo[1] && !(span > 3'd2);
            plan.slot[0].kind = CK_WRD;
            plan.slot[0].off  = 2'd0;
            if (span > 3'd2) begin
                plan.slot[1].kind = CK_WRD;
                plan.slot[1].off  = 2'd2;
            end
        end else begin
            case (len)
                2'd1: begin
                    plan.slot[0] = '{kind: CK_BWR, off: 2'd0, data: {ZB, wdata[7:0]}};
                end
                2'd2: begin
                    if (a_lo[0]) begin
                        plan.two     = 1'b1;
                        plan.slot[0] = '{kind: CK_BWR, off: 2'd0, data: {ZB, wdata[7:0]}};
                        plan.slot[1] = '{kind: CK_BWR, off: 2'd1, data: {ZB, wdata[15:8]}};
                    end else begin
                        plan.slot[0] = '{kind: CK_WWR, off: 2'd0, data: wdata[15:0]};
                    end
                end
                2'd3: begin
                    plan.two = 1'b1;
                    if (a_lo[0]) begin
                        plan.slot[0] = '{kind: CK_BWR, off: 2'd0, data: {ZB, wdata[7:0]}};
                        plan.slot[1] = '{kind: CK_WWR, off: 2'd1, data: wdata[23:8]};
                    end else begin
                        plan.slot[0] = '{kind: CK_WWR, off: 2'd0, data: wdata[15:0]};
                        plan.slot[1] = '{kind: CK_BWR, off: 2'd2, data: {ZB, wdata[23:16]}};
                    end
                end
                default: begin
                    plan = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/wbseq_fsm.sv
module wbseq_fsm
    import wbseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bad,
    input  logic two,
    input  logic ack,
    output logic cyc,
    output logic sel,
    output logic cap0,
    output logic cap1,
    output logic busy,
    output logic done,
    output logic err
);

    st_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = bad ? ST_REJECT : ST_FIRST;
            end
            ST_FIRST: begin
                if (ack) state_nx = two ? ST_SECOND : ST_FINISH;
            end
            ST_SECOND: begin
                if (ack) state_nx = ST_FINISH;
            end
            ST_FINISH: state_nx = ST_IDLE;
            ST_REJECT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cyc  = 1'b0;
        sel  = 1'b0;
        cap0 = 1'b0;
        cap1 = 1'b0;
        done = 1'b0;
        err  = 1'b0;
        busy = 1'b1;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_FIRST: begin
                cyc  = 1'b1;
                cap0 = ack;
            end
            ST_SECOND: begin
                cyc  = 1'b1;
                sel  = 1'b1;
                cap1 = ack;
            end
            ST_FINISH: done = 1'b1;
            ST_REJECT: err  = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/wbseq_rdpack.sv
module wbseq_rdpack
    import wbseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap0,
    input  logic             cap1,
    input  logic [BUS_W-1:0] word_in,
    input  logic             two,
    input  logic             hi,
    output logic [RES_W-1:0] rdata
);

    logic [NSLOT-1:0][BUS_W-1:0] words;
    logic [NSLOT-1:0]            cap;

    always_comb begin
        cap = {cap1, cap0};
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      words[k] <= '0;
            else if (cap[k]) words[k] <= word_in;
        end
    end

    always_comb begin
        if (two)     rdata = {words[1], words[0]};
        else if (hi) rdata = {words[0], {BUS_W{1'b0}}};
        else         rdata = {{BUS_W{1'b0}}, words[0]};
    end

endmodule

// File: rtl/wbus_io_seq.sv
module wbus_io_seq
    import wbseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_len,
    input  logic [23:0]         req_wdata,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [31:0]         rdata,
    output logic                bus_cyc,
    output logic                bus_we,
    output logic                bus_byte,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [15:0]         bus_wdata,
    input  logic [15:0]         bus_rdata,
    input  logic                bus_ack
);

    plan_t             plan_c;
    plan_t             plan_q;
    logic              bad_c;
    logic              start;
    logic              sel;
    logic              cap0;
    logic              cap1;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] slot_addr [NSLOT];
    slot_t             cur;

    wbseq_planner u_plan (
        .wr    (req_write),
        .a_lo  (req_addr[1:0]),
        .len   (req_len),
        .wdata (req_wdata),
        .plan  (plan_c),
        .bad   (bad_c)
    );

    always_comb begin
        start = req_valid && !busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plan_q <= '0;
            base_q <= '0;
        end else if (start && !bad_c) begin
            plan_q <= plan_c;
            base_q <= req_addr;
        end
    end

    wbseq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .bad   (bad_c),
        .two   (plan_q.two),
        .ack   (bus_ack),
        .cyc   (bus_cyc),
        .sel   (sel),
        .cap0  (cap0),
        .cap1  (cap1),
        .busy  (busy),
        .done  (done),
        .err   (err)
    );

    always_comb begin
        base_eff = plan_q.align ? {base_q[ADDR_W-1:1], 1'b0} : base_q;
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        always_comb begin
            slot_addr[k] = base_eff + ADDR_W'(plan_q.slot[k].off);
        end
    end

    always_comb begin
        cur       = sel ? plan_q.slot[1] : plan_q.slot[0];
        bus_addr  = sel ? slot_addr[1] : slot_addr[0];
        bus_we    = (cur.kind == CK_WWR) || (cur.kind == CK_BWR);
        bus_byte  = (cur.kind == CK_BWR);
        bus_wdata = cur.data;
    end

    wbseq_rdpack u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap0    (cap0),
        .cap1    (cap1),
        .word_in (bus_rdata),
        .two     (plan_q.two),
        .hi      (plan_q.hi),
        .rdata   (rdata)
    );

endmodule

// File: rtl/wbus_io_seq_chk.sv
module wbus_io_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              bus_cyc,
    input logic              bus_we,
    input logic              bus_byte,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              bus_ack
);

    logic [1:0] ack_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               ack_cnt <= '0;
        else if (!busy)           ack_cnt <= '0;
        else if (bus_cyc && bus_ack && ack_cnt != 2'd3)
                                  ack_cnt <= ack_cnt + 2'd1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_cyc && !done && !err);

    p_read_is_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && !bus_we |-> !bus_byte);

    p_word_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && !bus_byte |-> !bus_addr[0]);

    p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && bus_byte |-> bus_we && bus_wdata[15:8] == 8'h00);

    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && !bus_ack |=> bus_cyc && $stable(bus_addr) && $stable(bus_we)
                                && $stable(bus_byte) && $stable(bus_wdata));

    p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_ack) && !bus_cyc);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_err_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !bus_cyc && !done && ack_cnt == 2'd0);

    p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    p_cycle_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && bus_ack |-> ack_cnt < 2'd2);

endmodule

bind wbus_io_seq wbus_io_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .bus_cyc   (bus_cyc),
    .bus_we    (bus_we),
    .bus_byte  (bus_byte),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/test_wbus_io_seq.sv
module test_wbus_io_seq;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_len = '0;
    logic [23:0]   req_wdata = '0;
    logic          busy, done, err;
    logic [31:0]   rdata;
    logic          bus_cyc, bus_we, bus_byte;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata;
    logic [15:0]   bus_rdata = '0;
    logic          bus_ack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    wbus_io_seq #(.ADDR_W(AW)) i_wbus_io_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_byte(bus_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    always #4 clk = ~clk;

    // bus model
    int            log_n = 0;
    logic [AW-1:0] log_addr [4];
    logic          log_we [4];
    logic          log_byte [4];
    logic [15:0]   log_data [4];
    int            wait_left = 0;
    bit            prev_wait = 0;
    logic [AW+17:0] prev_snap = '0;
    int            hold_bad = 0;

    function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
        logic [31:0] t;
        t = 32'(a) * 32'h9E37 + 32'h5A5A;
        return t[15:0] ^ t[31:16];
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack   = 1'b0;
            prev_wait = 0;
        end else if (bus_ack) begin
            bus_ack   = 1'b0;
            wait_left = int'($urandom % 3);
        end else if (bus_cyc) begin
            if (prev_wait && prev_snap != {bus_addr, bus_we, bus_byte, bus_wdata})
                hold_bad++;
            if (wait_left == 0) begin
                bus_ack   = 1'b1;
                bus_rdata = mem_word({bus_addr[AW-1:1], 1'b0});
                if (log_n < 4) begin
                    log_addr[log_n] = bus_addr;
                    log_we[log_n]   = bus_we;
                    log_byte[log_n] = bus_byte;
                    log_data[log_n] = bus_wdata;
                end
                log_n++;
                prev_wait = 0;
            end else begin
                wait_left--;
                prev_wait = 1;
                prev_snap = {bus_addr, bus_we, bus_byte, bus_wdata};
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected cycles
    int            e_n;
    logic [AW-1:0] e_addr [2];
    logic          e_we [2];
    logic          e_byte [2];
    logic [15:0]   e_data [2];
    logic [31:0]   e_rd;

    task automatic expect_cycles(input bit wr, input logic [AW-1:0] a,
                                 input logic [1:0] l, input logic [23:0] wd,
                                 output string tag);
        logic [AW-1:0] ev;
        ev = {a[AW-1:1], 1'b0};
        e_rd = '0;
        for (int i = 0; i < 2; i++) begin
            e_we[i] = wr; e_byte[i] = 1'b0; e_data[i] = '0; e_addr[i] = a;
        end
        if (!wr) begin
            if (int'(l) + int'(a[0]) <= 2) begin
                tag = "R3"; e_n = 1; e_addr[0] = ev;
                e_rd = a[1] ? {mem_word(ev), 16'h0} : {16'h0, mem_word(ev)};
            end else begin
                tag = "R4"; e_n = 2; e_addr[0] = ev; e_addr[1] = ev + 2;
                e_rd = {mem_word(ev + 2), mem_word(ev)};
            end
        end else if (l == 2'd1) begin
            tag = "R5"; e_n = 1; e_byte[0] = 1; e_data[0] = {8'h0, wd[7:0]};
        end else if (l == 2'd2 && !a[0]) begin
            tag = "R6"; e_n = 1; e_data[0] = wd[15:0];
        end else if (l == 2'd2) begin
            tag = "R6"; e_n = 2;
            e_byte[0] = 1; e_data[0] = {8'h0, wd[7:0]};
            e_byte[1] = 1; e_data[1] = {8'h0, wd[15:8]}; e_addr[1] = a + 1;
        end else if (a[0]) begin
            tag = "R7"; e_n = 2;
            e_byte[0] = 1; e_data[0] = {8'h0, wd[7:0]};
            e_data[1] = wd[23:8]; e_addr[1] = a + 1;
        end else begin
            tag = "R7"; e_n = 2;
            e_data[0] = wd[15:0];
            e_byte[1] = 1; e_data[1] = {8'h0, wd[23:16]}; e_addr[1] = a + 2;
        end
    endtask

    task automatic run_req(input bit wr, input logic [AW-1:0] a, input logic [1:0] l,
                           input logic [23:0] wd, input bit poke);
        string tag;
        bit    s_done, s_err;
        logic [31:0] got;
        if (l != 2'd0) expect_cycles(wr, a, l, wd, tag);
        @(negedge clk);
        log_n = 0;
        req_valid = 1; req_write = wr; req_addr = a; req_len = l; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            // R11: stray request while busy
            req_valid = 1; req_write = ~wr; req_len = 2'd3; req_addr = a + 16'h41;
            req_wdata = ~wd;
            @(negedge clk);
            req_valid = 0;
        end
        s_done = 0; s_err = 0; got = '0;
        for (int i = 0; i < 60; i++) begin
            if (done) begin s_done = 1; got = rdata; end
            if (err) s_err = 1;
            if (s_done || s_err) break;
            @(negedge clk);
        end
        if (l == 2'd0) begin
            check(s_err && !s_done && log_n == 0, "R10", "zero length refused",
                  {s_done, s_err, 30'(log_n)}, {2'b01, 30'd0});
            @(negedge clk);
            check(!err && !busy, "R10", "err one cycle", {err, busy}, 0);
            return;
        end
        check(s_done && !s_err, "R9", "done seen", {s_done, s_err}, 2'b10);
        check(log_n == e_n, poke ? "R11" : "R12", "cycle count", log_n, e_n);
        for (int i = 0; i < 2; i++) begin
            if (i < e_n && i < log_n) begin
                check(log_addr[i] == e_addr[i] && log_we[i] == e_we[i] &&
                      log_byte[i] == e_byte[i] && (!wr || log_data[i] == e_data[i]),
                      poke ? "R11" : tag, $sformatf("cycle %0d", i),
                      {log_addr[i], log_we[i], log_byte[i], 14'(log_data[i])},
                      {e_addr[i], e_we[i], e_byte[i], 14'(e_data[i])});
                if (!wr)
                    check(!log_byte[i] && !log_addr[i][0], "R2", "word read",
                          {log_byte[i], log_addr[i][0]}, 0);
            end
        end
        if (!wr) check(got == e_rd, tag, "read result", got, e_rd);
        @(negedge clk);
        check(!done && !busy, "R9", "done pulse ends", {done, busy}, 0);
    endtask

    bit wd_hit = 0;

    initial begin
        #(8 * 150000);
        wd_hit = 1;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !err && !bus_cyc, "R1", "reset outputs",
              {busy, done, err, bus_cyc}, 0);
        // directed: every length, offset, direction
        for (int w = 0; w < 2; w++)
            for (int l = 1; l <= 3; l++)
                for (int o = 0; o < 4; o++)
                    run_req(w[0], 16'h1230 + AW'(o), l[1:0], 24'hC3A5F1, 0);
        // R10 zero length, R11 stray request
        run_req(0, 16'h0007, 2'd0, 24'h0, 0);
        run_req(1, 16'h0100, 2'd0, 24'h123456, 0);
        run_req(1, 16'h2003, 2'd3, 24'hABCDEF, 1);
        run_req(0, 16'h2001, 2'd3, 24'h0, 1);
        run_req(1, 16'hFFFE, 2'd3, 24'h777888, 0);
        // random mix
        for (int k = 0; k < 300; k++) begin
            run_req($urandom % 2, AW'($urandom), 2'(1 + $urandom % 3),
                    24'($urandom), ($urandom % 8) == 0);
        end
        // R8 hold while waiting
        check(hold_bad == 0, "R8", "fields held until ack", hold_bad, 0);
        if (!wd_hit) begin
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule